// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Engine

This block encrypts one 128-bit block under AES-128 using a small sequential datapath. Only one S-box, one column mixer and one XOR are in use in any cycle. Plaintext is written one byte per cycle through an addressed 8-bit load port. A held start input then runs the engine. The engine raises a done flag, and the caller reads the ciphertext back through the same address bus, one byte at a time, two cycles after each address.

The key schedule is not computed here. The engine drives an address into an external round-key store and takes the addressed key byte back in the same cycle. The store is arranged as eleven 16-byte round keys: round key r, byte b sits at entry r*16+b. Because the expanded key lives outside the block, it can be reused across any number of blocks.

Each pass over the state fuses a round-key addition with the byte substitution of the following round. The whole run therefore takes 222 cycles: ten substitution passes of 16 cycles, ten one-cycle row rotations, nine column-mix passes of 4 cycles, and a closing 16-cycle key addition.

Top module: `aes_byte_encryptor`

## Requirements
- R1: `rst` is an active-high asynchronous reset. While it is asserted and right after it, `done` is 0, `ct_byte` is 0 and every stored state byte is 0.
- R2: In idle, while `ld_en` is high, `ld_data` is stored as the byte at address `byte_addr` (0..15). Byte k is state row k mod 4, column k div 4. Addresses 16..31 are ignored, and in idle no state byte changes without a load.
- R3: `ct_byte` shows the stored byte for the address presented two rising edges earlier. Addresses 16..31 read as 0.
- R4: The result is AES-128 of the loaded block, where byte 0 is the first (most significant) byte. Round key r, byte b is read from `rk_addr` = r*16+b. Key 121323344556677889ffeeddeaa1b1b2 with plaintext 0a0b0c0d445566771a1b1c1d01020304 gives 69bf969db6c11b1ad3c66461f743a09f.
- R5: `done` rises exactly 222 rising edges after the edge that first samples `go` high in idle.
- R6: While `go` stays high, `done` stays high. One edge after `go` is low, `done` is 0 and the engine is idle.
- R7: If `go` falls before `done`, the run is abandoned, `done` does not assert and new loads are accepted.
- R8: `ld_en` pulses while a run is in progress have no effect on the state or the result.
- R9: A load on the same edge that first samples `go` is stored before the run starts and is part of the encrypted block.
- R10: `rk_addr` never exceeds 175.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| ld_en | input | 1 | Plaintext byte write strobe |
| ld_data | input | 8 | Plaintext byte |
| byte_addr | input | 5 | Byte address for load and readback |
| go | input | 1 | Start; held high until done |
| rk_addr | output | 8 | Round-key store address (round*16+byte) |
| rk_data | input | 8 | Round-key byte at rk_addr, same cycle |
| done | output | 1 | Encryption complete |
| ct_byte | output | 8 | Readback byte, two cycles after address |

## Verification
Loading and starting share an edge when `ld_en` carries the last plaintext byte in the same cycle that `go` first rises. The bench provokes this on purpose and expects the final ciphertext to include that byte. Loading and running can also overlap: bytes are written while the engine is busy, and the result must be unchanged. The address bus carries readback and load traffic at once. The bench therefore checks readback latency against the byte that was held before, and checks that out-of-range addresses stay inert for both uses. Expected blocks come from an independent log/antilog model of the cipher in the bench, with seeded random keys and plaintexts.

// File: rtl/aesb_pkg.sv
package aesb_pkg;
  localparam int NBYTES  = 16;
  localparam int NCOLS   = 4;
  localparam int NROUNDS = 10;
  localparam int IDX_W   = $clog2(NBYTES);
  localparam int RND_W   = $clog2(NROUNDS + 1);

  typedef enum logic [2:0] {
    PH_IDLE, PH_SUBKEY, PH_SHIFT, PH_MIX, PH_LASTKEY, PH_DONE
  } phase_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (maps 0 to 0)
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int k = 1; k < 8; k++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] b;
    b = ginv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  // column packed as {row3,row2,row1,row0}
  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    a0 = c[7:0]; a1 = c[15:8]; a2 = c[23:16]; a3 = c[31:24];
    return {xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3),
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3};
  endfunction
endpackage

// File: rtl/aesb_ctrl.sv
module aesb_ctrl
  import aesb_pkg::*;
#(
  parameter int ROUNDS = NROUNDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  output phase_t           phase,
  output logic [IDX_W-1:0] idx,
  output logic [RND_W-1:0] rnd,
  output logic             ev_start,
  output logic             done
);
  localparam int RUN_CYCLES = ROUNDS * (NBYTES + 1) + (ROUNDS - 1) * NCOLS + NBYTES;
  localparam int CW = $clog2(RUN_CYCLES + 2);

  logic ev_last_byte, ev_last_col, ev_final_rnd, busy;

  assign ev_start     = (phase == PH_IDLE) && go;
  assign ev_last_byte = (idx == IDX_W'(NBYTES - 1));
  assign ev_last_col  = (idx == IDX_W'(NCOLS - 1));
  assign ev_final_rnd = (rnd == RND_W'(ROUNDS));
  assign busy         = (phase != PH_IDLE) && (phase != PH_DONE);
  assign done         = (phase == PH_DONE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_IDLE;
      idx   <= '0;
      rnd   <= '0;
    end else if (phase != PH_IDLE && !go) begin
      phase <= PH_IDLE;
      idx   <= '0;
      rnd   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          phase <= PH_SUBKEY;
          idx   <= '0;
          rnd   <= RND_W'(1);
        end
        PH_SUBKEY: begin
          idx <= idx + 1'b1;
          if (ev_last_byte) phase <= PH_SHIFT;
        end
        PH_SHIFT: begin
          idx   <= '0;
          phase <= ev_final_rnd ? PH_LASTKEY : PH_MIX;
        end
        PH_MIX: if (ev_last_col) begin
          idx   <= '0;
          rnd   <= rnd + 1'b1;
          phase <= PH_SUBKEY;
        end else begin
          idx <= idx + 1'b1;
        end
        PH_LASTKEY: begin
          idx <= idx + 1'b1;
          if (ev_last_byte) phase <= PH_DONE;
        end
        PH_DONE: ;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // cycle counter used only by the run-length check
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)           run_cnt <= '0;
    else if (ev_start) run_cnt <= '0;
    else if (busy)     run_cnt <= run_cnt + 1'b1;
  end

  // R5
  run_length_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> run_cnt == CW'(RUN_CYCLES));
endmodule

// File: rtl/aesb_state.sv
module aesb_state
  import aesb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase,
  input  logic [IDX_W-1:0] idx,
  input  logic             ld_we,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [7:0]       ld_data,
  input  logic [7:0]       rk_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte
);
  logic [7:0]  st      [NBYTES];
  logic [7:0]  shifted [NBYTES];
  logic [7:0]  sub_out, key_out;
  logic [31:0] mix_in, mix_out;
  logic [1:0]  col;
  logic [8*NBYTES-1:0] st_flat;

  assign col     = idx[1:0];
  assign key_out = st[idx] ^ rk_byte;
  assign sub_out = sbox(key_out);
  assign mix_in  = {st[{col, 2'd3}], st[{col, 2'd2}], st[{col, 2'd1}], st[{col, 2'd0}]};
  assign mix_out = mix_col(mix_in);
  assign rd_byte = st[rd_idx];

  // row r rotates left by r columns
  always_comb begin
    for (int c = 0; c < NCOLS; c++)
      for (int r = 0; r < 4; r++)
        shifted[r + 4 * c] = st[r + 4 * ((c + r) % NCOLS)];
  end

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_flat
      assign st_flat[8*g +: 8] = st[g];
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) st[i] <= 8'h00;
    end else begin
      case (phase)
        PH_IDLE:    if (ld_we) st[ld_idx] <= ld_data;
        PH_SUBKEY:  st[idx] <= sub_out;
        PH_SHIFT:   for (int i = 0; i < NBYTES; i++) st[i] <= shifted[i];
        PH_MIX:     for (int j = 0; j < 4; j++) st[{col, 2'(j)}] <= mix_out[8*j +: 8];
        PH_LASTKEY: st[idx] <= key_out;
        default: ;
      endcase
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !ld_we) |=> $stable(st_flat));
endmodule

// File: rtl/aesb_rdport.sv
module aesb_rdport
  import aesb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       addr,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_byte,
  output logic [7:0]       dout
);
  logic [4:0] addr_q;
  logic       ev_out_of_range;

  assign rd_idx          = addr_q[IDX_W-1:0];
  assign ev_out_of_range = addr_q[4];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      addr_q <= '0;
      dout   <= 8'h00;
    end else begin
      addr_q <= addr;
      dout   <= ev_out_of_range ? 8'h00 : rd_byte;
    end
  end

  // R3
  high_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) >= 5'd16) |=> dout == 8'h00);
endmodule

// File: rtl/aes_byte_encryptor.sv
module aes_byte_encryptor
  import aesb_pkg::*;
#(
  parameter int ROUNDS = NROUNDS,
  parameter int RK_AW  = $clog2((NROUNDS + 1) * NBYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [7:0]       ld_data,
  input  logic [4:0]       byte_addr,
  input  logic             go,
  output logic [RK_AW-1:0] rk_addr,
  input  logic [7:0]       rk_data,
  output logic             done,
  output logic [7:0]       ct_byte
);
  localparam int RK_ENTRIES = (ROUNDS + 1) * NBYTES;

  phase_t           phase;
  logic [IDX_W-1:0] idx, rd_idx;
  logic [RND_W-1:0] rnd;
  logic             ev_start, ld_we, key_phase;
  logic [7:0]       rd_byte;
  logic [RND_W-1:0] key_rnd;

  assign ld_we     = ld_en && (phase == PH_IDLE) && !byte_addr[4];
  assign key_phase = (phase == PH_SUBKEY) || (phase == PH_LASTKEY);
  assign key_rnd   = (phase == PH_LASTKEY) ? RND_W'(ROUNDS) : rnd - 1'b1;
  assign rk_addr   = key_phase ? RK_AW'({key_rnd, idx}) : '0;

  aesb_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .phase(phase), .idx(idx), .rnd(rnd),
    .ev_start(ev_start), .done(done)
  );

  aesb_state u_state (
    .clk(clk), .rst(rst), .phase(phase), .idx(idx), .ld_we(ld_we),
    .ld_idx(byte_addr[IDX_W-1:0]), .ld_data(ld_data), .rk_byte(rk_data),
    .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  aesb_rdport u_rd (
    .clk(clk), .rst(rst), .addr(byte_addr), .rd_idx(rd_idx),
    .rd_byte(rd_byte), .dout(ct_byte)
  );

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && go) |=> done);

  // R7
  go_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> !done);

  // R10
  rk_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(rk_addr) < RK_ENTRIES);
endmodule

// File: tb/tb_aes_byte_encryptor.sv
module tb_aes_byte_encryptor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic [4:0] byte_addr = 5'd0;
  logic       go = 1'b0;
  logic [7:0] rk_addr;
  logic [7:0] rk_data;
  logic       done;
  logic [7:0] ct_byte;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] kw [176];
  int bexp [256];
  int blog [256];
  logic [7:0] bsb [256];

  always #2 clk = ~clk;

  assign rk_data = (rk_addr < 8'd176) ? kw[rk_addr] : 8'h00;

  aes_byte_encryptor dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_data(ld_data), .byte_addr(byte_addr),
    .go(go), .rk_addr(rk_addr), .rk_data(rk_data), .done(done), .ct_byte(ct_byte)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return 8'(bexp[(blog[a] + blog[b]) % 255]);
  endfunction

  task automatic build_tables();
    bexp[0] = 1;
    for (int i = 1; i < 256; i++) begin
      logic [7:0] x;
      x = 8'(bexp[i-1]);
      bexp[i] = int'(x ^ ({x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00)));
    end
    for (int i = 0; i < 255; i++) blog[bexp[i]] = i;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] v, s;
      v = (a == 0) ? 8'h00 : 8'(bexp[(255 - blog[a]) % 255]);
      for (int i = 0; i < 8; i++)
        s[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ ((8'h63 >> i) & 1);
      bsb[a] = s;
    end
  endtask

  task automatic set_key(input logic [127:0] key);
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) kw[i] = key[127-8*i -: 8];
    for (int i = 16; i < 176; i += 4) begin
      logic [7:0] t [4];
      for (int j = 0; j < 4; j++) t[j] = kw[i-4+j];
      if (i % 16 == 0) begin
        logic [7:0] t0;
        t0 = t[0];
        t[0] = bsb[t[1]] ^ rc; t[1] = bsb[t[2]]; t[2] = bsb[t[3]]; t[3] = bsb[t0];
        rc = bmul(rc, 8'h02);
      end
      for (int j = 0; j < 4; j++) kw[i+j] = kw[i-16+j] ^ t[j];
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] res;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ kw[i];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) t[i] = bsb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) s[w + 4*c] = t[w + 4*((c + w) % 4)];
      if (r < 10) begin
        for (int c = 0; c < 4; c++)
          for (int w = 0; w < 4; w++)
            t[w + 4*c] = bmul(8'h02, s[4*c + w]) ^ bmul(8'h03, s[4*c + (w+1)%4])
                       ^ s[4*c + (w+2)%4] ^ s[4*c + (w+3)%4];
        for (int i = 0; i < 16; i++) s[i] = t[i];
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ kw[16*r + i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic load_block(input logic [127:0] pt);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      ld_en = 1'b1; byte_addr = 5'(k); ld_data = pt[127-8*k -: 8];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // go already high at this negedge; returns posedges until done seen
  task automatic wait_done(output int n);
    n = 0;
    while (n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic read_block(output logic [127:0] ct);
    for (int k = 0; k < 16; k++) begin
      byte_addr = 5'(k);
      @(negedge clk); @(negedge clk);
      ct[127-8*k -: 8] = ct_byte;
    end
  endtask

  task automatic full_run(input logic [127:0] pt, output logic [127:0] ct, output int n);
    load_block(pt);
    go = 1'b1;
    wait_done(n);
    read_block(ct);
    go = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] ct, pt, key, exp;
    logic [7:0] b15;
    int n;
    void'($urandom(32'h5eed_a11e));
    build_tables();
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 128'(done), 0);
    check(ct_byte == 8'h00, "R1 ct_byte in reset", 128'(ct_byte), 0);
    rst = 1'b0;
    @(negedge clk);

    // known vector, run length, done handshake
    key = 128'h121323344556677889ffeeddeaa1b1b2;
    pt  = 128'h0a0b0c0d445566771a1b1c1d01020304;
    set_key(key);
    load_block(pt);
    go = 1'b1;
    wait_done(n);
    check(n == 223, "R5 run length", 128'(n), 223);
    read_block(ct);
    check(ct == 128'h69bf969db6c11b1ad3c66461f743a09f, "R4 known vector", ct,
          128'h69bf969db6c11b1ad3c66461f743a09f);
    check(ct == ref_enc(pt), "R4 bench model", ct, ref_enc(pt));
    // R3 latency: byte 15 held, now present address 0
    b15 = ct[7:0];
    byte_addr = 5'd0;
    @(negedge clk);
    check(ct_byte == b15, "R3 one edge keeps old byte", 128'(ct_byte), 128'(b15));
    @(negedge clk);
    check(ct_byte == ct[127:120], "R3 two edges gives new byte", 128'(ct_byte), 128'(ct[127:120]));
    byte_addr = 5'd20;
    @(negedge clk); @(negedge clk);
    check(ct_byte == 8'h00, "R3 high address reads zero", 128'(ct_byte), 0);
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R6 done held with go", 128'(done), 1);
    go = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R6 done drops after go low", 128'(done), 0);

    // random blocks under random keys
    for (int it = 0; it < 6; it++) begin
      key = {$urandom, $urandom, $urandom, $urandom};
      pt  = {$urandom, $urandom, $urandom, $urandom};
      set_key(key);
      full_run(pt, ct, n);
      exp = ref_enc(pt);
      check(ct == exp && n == 223, "R4 random block", ct, exp);
    end

    // R2: high addresses ignored on load, readback before run
    pt = {$urandom, $urandom, $urandom, $urandom};
    load_block(pt);
    for (int k = 16; k < 32; k++) begin
      @(negedge clk);
      ld_en = 1'b1; byte_addr = 5'(k); ld_data = 8'($urandom);
    end
    @(negedge clk);
    ld_en = 1'b0;
    read_block(ct);
    check(ct == pt, "R2 readback of loaded block", ct, pt);
    go = 1'b1;
    wait_done(n);
    read_block(ct);
    go = 1'b0;
    @(negedge clk);
    check(ct == ref_enc(pt), "R2 high-address writes ignored", ct, ref_enc(pt));

    // R8: loads during a run
    pt = {$urandom, $urandom, $urandom, $urandom};
    load_block(pt);
    go = 1'b1;
    repeat (30) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      ld_en = 1'b1; byte_addr = 5'(k); ld_data = 8'($urandom);
      @(negedge clk);
    end
    ld_en = 1'b0;
    wait_done(n);
    read_block(ct);
    go = 1'b0;
    @(negedge clk);
    check(ct == ref_enc(pt), "R8 busy loads ignored", ct, ref_enc(pt));

    // R7: abandoned run
    load_block(pt);
    go = 1'b1;
    repeat (40) @(negedge clk);
    go = 1'b0;
    n = 0;
    repeat (300) begin
      @(negedge clk);
      if (done) n++;
    end
    check(n == 0, "R7 no done after abort", 128'(n), 0);
    pt = {$urandom, $urandom, $urandom, $urandom};
    full_run(pt, ct, n);
    check(ct == ref_enc(pt), "R7 loads accepted after abort", ct, ref_enc(pt));

    // R9: last byte loaded on the start edge
    pt = {$urandom, $urandom, $urandom, $urandom};
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      ld_en = 1'b1; byte_addr = 5'(k); ld_data = pt[127-8*k -: 8];
    end
    @(negedge clk);
    byte_addr = 5'd15; ld_data = pt[7:0]; go = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
    wait_done(n);
    read_block(ct);
    go = 1'b0;
    @(negedge clk);
    check(ct == ref_enc(pt), "R9 load with go", ct, ref_enc(pt));

    // R1: asynchronous reset mid-run
    load_block(pt);
    go = 1'b1;
    repeat (50) @(negedge clk);
    #1 rst = 1'b1;
    #0.5;
    check(done == 1'b0 && ct_byte == 8'h00, "R1 async reset outputs", {done, ct_byte}, 0);
    go = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    byte_addr = 5'd3;
    @(negedge clk); @(negedge clk);
    check(ct_byte == 8'h00, "R1 state cleared", 128'(ct_byte), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule